// File: doc/BRIEF.md
# E1 Timeslot-16 Signaling Alarm Detector

This block watches a received E1 octet stream whose frame and multiframe positions are already known. For each octet it is given the timeslot number, the frame number inside the 16-frame multiframe, and a flag that marks the alternate frames that do not carry the frame alignment word. From this stream it keeps four alarm flags. Each flag is set by one rule and cleared by a different rule, so it holds its state between the two.

Two of the alarms judge the signaling timeslot (timeslot 16) over one whole multiframe. The first reports signaling that is nearly all ones. The second reports signaling that is all zeros. The third alarm follows a single bit that the far end sends in frame 0 of each multiframe. The fourth follows the remote-alarm bit that the far end sends in the alternate frames. When the upstream aligner reports that it has lost alignment, all partial counts are dropped and the flags keep their last state.

Top module: `ts16_alarm_det`

## Requirements
- R1: After reset, all four alarm outputs are 0.
- R2: A complete multiframe is the timeslot-16 octets of frames 0 to 15, received in that order with no frame missing. When such a multiframe holds fewer than 3 zero bits in total, `sig_ones_alarm` goes to 1 on the clock edge after the frame-15 octet is accepted.
- R3: When a complete multiframe holds 3 or more zero bits, `sig_ones_alarm` goes to 0 at that same point.
- R4: When all 128 timeslot-16 bits of a complete multiframe are 0, `sig_zeros_alarm` goes to 1. When a complete multiframe holds at least one 1 bit, it goes to 0. `sig_ones_alarm` and `sig_zeros_alarm` are never 1 at the same time.
- R5: Bits are numbered 1 (MSB, `oct_data[7]`) to 8 (LSB, `oct_data[0]`). Bit 6 (`oct_data[2]`) of the timeslot-16 octet in frame 0 is sampled once per multiframe. If it is 1 for two samples in a row, `dist_mf_alarm` goes to 1. If it is 0 for two samples in a row, `dist_mf_alarm` goes to 0. Each change appears on the edge after the second sample.
- R6: Bit 3 (`oct_data[5]`) of each timeslot-0 octet with `nonalign`=1 is one occasion. Three occasions in a row at 1 set `remote_alarm`. Three occasions in a row at 0 clear it. A shorter run has no effect.
- R7: A multiframe that starts at a frame other than 0, or that skips a frame number, is not evaluated. `sig_ones_alarm` and `sig_zeros_alarm` keep their state, and counting starts again at the next frame 0.
- R8: While `align_ok` is 0, the alarm outputs keep their state and all counts and runs are reset. A run of samples that began before the loss does not carry over past it.
- R9: These octets change nothing: octets with `oct_vld`=0, octets in timeslots other than 0 and 16, and timeslot-0 octets with `nonalign`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| align_ok | input | 1 | Frame/multiframe alignment is valid |
| oct_vld | input | 1 | Octet strobe |
| oct_data | input | 8 | Received octet, bit 1 in `oct_data[7]` |
| ts_num | input | 5 | Timeslot number of the octet (0..31) |
| frm_num | input | 4 | Frame number within the multiframe (0..15) |
| nonalign | input | 1 | Octet belongs to an alternate frame that does not carry the alignment word |
| sig_ones_alarm | output | 1 | Timeslot-16 nearly-all-ones alarm |
| sig_zeros_alarm | output | 1 | Timeslot-16 all-zeros alarm |
| dist_mf_alarm | output | 1 | Distant multiframe alarm |
| remote_alarm | output | 1 | Remote alarm |

## Verification
The bench places the zero count right on the threshold: two zeros must set the all-ones alarm and three must clear it. An off-by-one in the compare would leave the flag wrong after that multiframe. It sends multiframes that start late or skip a frame; a design that evaluated them anyway would raise the all-ones alarm from a partial count. Remote-alarm patterns break a run of ones with a single zero, so a design that counted ones without requiring them to be consecutive would set the alarm too early. An alignment loss between two frame-0 samples checks that the distant multiframe run restarts, and it shows up as a false alarm in a design that kept the old run. In every frame the bench also sends zero octets with the strobe low and in a foreign timeslot, plus alignment-word octets with bit 3 set. These catch a design with a loose strobe decode, which would either count extra zeros or take a false remote-alarm occasion.

// File: rtl/ts16_alarm_pkg.sv
package ts16_alarm_pkg;
  localparam int OCT_W        = 8;
  localparam int MF_LEN       = 16;
  localparam int TS_W         = 5;
  localparam int TS_SIG       = 16;
  localparam int TS_ALIGN     = 0;
  localparam int DMA_BIT_NUM  = 6;   // 1 = MSB
  localparam int RA_BIT_NUM   = 3;
  localparam int DMA_RUN      = 2;
  localparam int RA_RUN       = 3;
  localparam int ONES_ZERO_LIM = 3;

  typedef struct packed {
    logic ones;
    logic zeros;
    logic dist_mf;
    logic remote;
  } alarm_vec_t;
endpackage

// File: rtl/ts16_rst_sync.sv
module ts16_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ts16_mf_accum.sv
module ts16_mf_accum #(
  parameter int OCT_W    = 8,
  parameter int MF_LEN   = 16,
  parameter int ZERO_LIM = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      smp,
  input  logic [$clog2(MF_LEN)-1:0] frm,
  input  logic [OCT_W-1:0]          data,
  output logic                      ones_alarm,
  output logic                      zeros_alarm
);
  localparam int FW = $clog2(MF_LEN);
  localparam int ZW = $clog2(MF_LEN*OCT_W+1);
  localparam logic [FW-1:0] LAST_F  = FW'(MF_LEN-1);
  localparam logic [ZW-1:0] LIM_C   = ZW'(ZERO_LIM);
  localparam logic [ZW-1:0] ALL_Z   = ZW'(MF_LEN*OCT_W);

  logic          seq_q, seq_d;
  logic [FW-1:0] tcnt_q, tcnt_d;
  logic [ZW-1:0] zacc_q, zacc_d;
  logic          ones_q, ones_d, zeros_q, zeros_d;
  logic [ZW-1:0] z_oct, z_sum;

  always_comb begin
    z_oct = '0;
    for (int i = 0; i < OCT_W; i++) z_oct = z_oct + ZW'(!data[i]);
    z_sum = zacc_q + z_oct;
  end

  always_comb begin
    seq_d   = seq_q;
    tcnt_d  = tcnt_q;
    zacc_d  = zacc_q;
    ones_d  = ones_q;
    zeros_d = zeros_q;
    if (clr) begin
      seq_d  = 1'b0;
      tcnt_d = '0;
      zacc_d = '0;
    end else if (smp) begin
      if (frm == '0) begin
        seq_d  = 1'b1;
        tcnt_d = FW'(1);
        zacc_d = z_oct;
      end else if (seq_q && frm == tcnt_q) begin
        if (frm == LAST_F) begin
          ones_d  = (z_sum < LIM_C);
          zeros_d = (z_sum == ALL_Z);
          seq_d   = 1'b0;
          tcnt_d  = '0;
          zacc_d  = '0;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
          zacc_d = z_sum;
        end
      end else begin
        seq_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= 1'b0;
      tcnt_q  <= '0;
      zacc_q  <= '0;
      ones_q  <= 1'b0;
      zeros_q <= 1'b0;
    end else begin
      seq_q   <= seq_d;
      tcnt_q  <= tcnt_d;
      zacc_q  <= zacc_d;
      ones_q  <= ones_d;
      zeros_q <= zeros_d;
    end
  end

  assign ones_alarm  = ones_q;
  assign zeros_alarm = zeros_q;

  assert_sig_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ones_alarm && zeros_alarm));

  assert_no_eval_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp && frm == LAST_F) |=> $stable({ones_alarm, zeros_alarm}));
endmodule

// File: rtl/ts16_run_filter.sv
module ts16_run_filter #(
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic smp,
  input  logic bit_in,
  output logic alarm
);
  localparam int CW = $clog2(RUN+1);
  localparam logic [CW-1:0] RUN_C = CW'(RUN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_q, last_d;
  logic          alarm_q, alarm_d;

  always_comb begin
    cnt_d   = cnt_q;
    last_d  = last_q;
    alarm_d = alarm_q;
    if (clr) begin
      cnt_d = '0;
    end else if (smp) begin
      if (cnt_q != '0 && bit_in == last_q)
        cnt_d = (cnt_q == RUN_C) ? cnt_q : cnt_q + 1'b1;
      else
        cnt_d = CW'(1);
      last_d = bit_in;
      if (cnt_d == RUN_C) alarm_d = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      last_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm = alarm_q;

  // Shared by the R5 and R6 instances
  assert_run_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable(alarm));

  assert_run_set_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(smp && bit_in));
endmodule

// File: rtl/ts16_alarm_det.sv
module ts16_alarm_det
  import ts16_alarm_pkg::*;
#(
  parameter int W        = OCT_W,
  parameter int MFL      = MF_LEN,
  parameter int TSW      = TS_W,
  parameter int DMA_N    = DMA_RUN,
  parameter int RA_N     = RA_RUN,
  parameter int ZLIM     = ONES_ZERO_LIM
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   align_ok,
  input  logic                   oct_vld,
  input  logic [W-1:0]           oct_data,
  input  logic [TSW-1:0]         ts_num,
  input  logic [$clog2(MFL)-1:0] frm_num,
  input  logic                   nonalign,
  output logic                   sig_ones_alarm,
  output logic                   sig_zeros_alarm,
  output logic                   dist_mf_alarm,
  output logic                   remote_alarm
);
  localparam int DMA_IDX = W - DMA_BIT_NUM;
  localparam int RA_IDX  = W - RA_BIT_NUM;
  localparam logic [TSW-1:0] TS_SIG_C   = TSW'(TS_SIG);
  localparam logic [TSW-1:0] TS_ALIGN_C = TSW'(TS_ALIGN);

  logic rst_n_i;
  logic acc_en, sig_stb, dma_stb, ra_stb, clr;
  alarm_vec_t alm;

  ts16_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  always_comb begin
    clr     = !align_ok;
    acc_en  = oct_vld && align_ok;
    sig_stb = acc_en && (ts_num == TS_SIG_C);
    dma_stb = sig_stb && (frm_num == '0);
    ra_stb  = acc_en && (ts_num == TS_ALIGN_C) && nonalign;
  end

  ts16_mf_accum #(.OCT_W(W), .MF_LEN(MFL), .ZERO_LIM(ZLIM)) u_accum (
    .clk(clk), .rst_n(rst_n_i), .clr(clr), .smp(sig_stb),
    .frm(frm_num), .data(oct_data),
    .ones_alarm(alm.ones), .zeros_alarm(alm.zeros)
  );

  ts16_run_filter #(.RUN(DMA_N)) u_dma (
    .clk(clk), .rst_n(rst_n_i), .clr(clr), .smp(dma_stb),
    .bit_in(oct_data[DMA_IDX]), .alarm(alm.dist_mf)
  );

  ts16_run_filter #(.RUN(RA_N)) u_ra (
    .clk(clk), .rst_n(rst_n_i), .clr(clr), .smp(ra_stb),
    .bit_in(oct_data[RA_IDX]), .alarm(alm.remote)
  );

  assign sig_ones_alarm  = alm.ones;
  assign sig_zeros_alarm = alm.zeros;
  assign dist_mf_alarm   = alm.dist_mf;
  assign remote_alarm    = alm.remote;

  assert_align_loss_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !align_ok |=> $stable(alm));

  assert_foreign_ts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_num != TS_SIG_C && ts_num != TS_ALIGN_C) |=> $stable(alm));
endmodule

// File: tb/ts16_alarm_det_tb.sv
module ts16_alarm_det_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       align_ok = 1'b0, oct_vld = 1'b0, nonalign = 1'b0;
  logic [7:0] oct_data = '0;
  logic [4:0] ts_num = '0;
  logic [3:0] frm_num = '0;
  logic       sig_ones_alarm, sig_zeros_alarm, dist_mf_alarm, remote_alarm;

  always #5 clk = ~clk;

  ts16_alarm_det u_dut (
    .clk(clk), .rst_n(rst_n), .align_ok(align_ok), .oct_vld(oct_vld),
    .oct_data(oct_data), .ts_num(ts_num), .frm_num(frm_num), .nonalign(nonalign),
    .sig_ones_alarm(sig_ones_alarm), .sig_zeros_alarm(sig_zeros_alarm),
    .dist_mf_alarm(dist_mf_alarm), .remote_alarm(remote_alarm)
  );

  typedef struct { logic [3:0] exp; string tag; int due; } sb_item_t;
  sb_item_t sb[$];
  sb_item_t it;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  // bench model, written from the requirements
  bit m_seq; int m_cnt, m_z;
  logic m_ones, m_zeros, m_dma, m_ra;
  int dma_rc, ra_rc; logic dma_last, ra_last;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] act();
    return {sig_ones_alarm, sig_zeros_alarm, dist_mf_alarm, remote_alarm};
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      checks++;
      if (act() !== it.exp) begin
        errors++;
        $display("FAIL %s: alarms act=%b exp=%b", it.tag, act(), it.exp);
      end
    end
  end

  task automatic upd_run(input logic b, input int n, inout int rc, inout logic last, inout logic al);
    if (rc > 0 && b == last) rc = (rc >= n) ? n : rc + 1;
    else rc = 1;
    last = b;
    if (rc >= n) al = b;
  endtask

  task automatic drive(input logic vld, input logic [7:0] d, input int ts, input int f,
                       input logic na, input logic al, input string tag);
    @(negedge clk);
    oct_vld = vld; oct_data = d; ts_num = 5'(ts); frm_num = 4'(f);
    nonalign = na; align_ok = al;
    if (!al) begin
      m_seq = 0; m_cnt = 0; m_z = 0; dma_rc = 0; ra_rc = 0;
    end else if (vld) begin
      if (ts == 16) begin
        if (f == 0) begin
          m_seq = 1; m_cnt = 1; m_z = 8 - $countones(d);
        end else if (m_seq && f == m_cnt) begin
          m_z += 8 - $countones(d); m_cnt++;
          if (m_cnt == 16) begin
            m_ones = (m_z < 3); m_zeros = (m_z == 128); m_seq = 0;
          end
        end else m_seq = 0;
        if (f == 0) upd_run(d[2], 2, dma_rc, dma_last, m_dma);
      end
      if (ts == 0 && na) upd_run(d[5], 3, ra_rc, ra_last, m_ra);
    end
    sb.push_back('{exp: {m_ones, m_zeros, m_dma, m_ra}, tag: tag, due: cyc + 1});
  endtask

  // One multiframe; per frame: TS0, a foreign TS zero octet, a strobe-low TS16 zero octet, TS16 (R9)
  task automatic send_mf(input int first, input int skip, input logic [7:0] base,
                         input logic [7:0] f0, input int spot_f, input logic [7:0] spot_v,
                         input logic [7:0] ra_pat, input string tag);
    for (int f = first; f < 16; f++) begin
      logic na;
      logic [7:0] v;
      if (f == skip) continue;
      na = (f % 2 == 1);
      drive(1, na ? (ra_pat[f/2] ? 8'h20 : 8'h00) : 8'h3B, 0, f, na, 1, tag);
      drive(1, 8'h00, 5, f, 0, 1, tag);
      drive(0, 8'h00, 16, f, 0, 1, tag);
      v = (f == 0) ? f0 : ((f == spot_f) ? spot_v : base);
      drive(1, v, 16, f, 0, 1, tag);
    end
  endtask

  task automatic expect_now(input logic [3:0] e, input string tag);
    @(negedge clk);
    checks++;
    if (act() !== e) begin
      errors++;
      $display("FAIL %s: alarms act=%b exp=%b", tag, act(), e);
    end
  endtask

  initial begin
    m_seq = 0; m_cnt = 0; m_z = 0; m_ones = 0; m_zeros = 0; m_dma = 0; m_ra = 0;
    dma_rc = 0; ra_rc = 0; dma_last = 0; ra_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_now(4'b0000, "R1 reset");
    send_mf(0, -1, 8'hFF, 8'hFB, 5, 8'hFE, 8'h00, "R2 two zeros");
    expect_now(4'b1000, "R2 set");
    send_mf(0, -1, 8'hFF, 8'hFF, 7, 8'hF8, 8'h00, "R3 three zeros");
    expect_now(4'b0000, "R3 clear");
    send_mf(0, -1, 8'hFF, 8'hFF, -1, 8'h00, 8'h00, "R5 second one");
    expect_now(4'b1010, "R5 set / R9 ignored zeros");
    send_mf(0, -1, 8'h00, 8'h00, -1, 8'h00, 8'h00, "R4 all zero");
    expect_now(4'b0110, "R4 set");
    send_mf(0, -1, 8'h00, 8'h00, 9, 8'h01, 8'h07, "R4 one bit / R6 run");
    expect_now(4'b0000, "R4 clear / R5 clear / R6 cleared");
    send_mf(0, -1, 8'h55, 8'h55, -1, 8'h00, 8'h3B, "R6 broken run");
    expect_now(4'b0001, "R6 set after three");
    send_mf(4, -1, 8'hFF, 8'hFF, -1, 8'h00, 8'h00, "R7 late start");
    expect_now(4'b0000, "R7 late start held");
    send_mf(0, 8, 8'hFF, 8'hFB, -1, 8'h00, 8'h00, "R7 gap");
    expect_now(4'b0000, "R7 gap held");
    send_mf(0, -1, 8'hFF, 8'hFF, -1, 8'h00, 8'h00, "R8 before loss");
    drive(1, 8'h00, 16, 0, 0, 0, "R8 loss");
    drive(0, 8'h00, 16, 0, 0, 0, "R8 loss");
    expect_now(4'b1000, "R8 hold during loss");
    send_mf(0, -1, 8'h00, 8'h04, -1, 8'h00, 8'h00, "R8 after loss");
    expect_now(4'b0000, "R8 run restarted");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule